// File: doc/BRIEF.md
# Partitioned Column-Compression Multiplier

This block multiplies two unsigned 16-bit operands and returns the full 32-bit product. It does not build one tall partial-product matrix. Instead, the multiplier bits are split into a low group and a high group, giving two shorter matrices. Each matrix is shrunk to two rows on its own by Dadda column compression, which uses full-adder and half-adder counters only where the next height target needs them. Each of the two partitions then resolves its two rows with its own carry-propagate adder.

The two partition products overlap across a band of columns. The bits below that band come straight from the low partition. The band itself is summed by a short ripple-carry adder. The bits above the band come from a carry-select stage. That stage either passes the high partition's upper bits through or passes their +1 form, which an excess-1 converter produces. The ripple adder's carry-out picks between the two.

The operand width and the split point are parameters. A parameter also selects an output register, which is on by default, so the product normally appears one clock after the operands.

Top module: `dadda_split_mul`

## Requirements
- R1: `prod_o` equals the unsigned product of `a_i` and `b_i` as a 32-bit value, for every pair of operand values, including all-zeros and all-ones.
- R2: With the output register enabled (default), `prod_o` shows the product of the operands that were present at a rising clock edge, right after that edge. While `rst_ni` is low, `prod_o` is 0.
- R3: The low partition covers multiplier bits [7:0] and yields `a_i * b_i[7:0]` as 24 bits. With `b_i[15:8]` = 0, the product is exactly that value.
- R4: The high partition covers multiplier bits [15:8] and yields `a_i * b_i[15:8]` as 24 bits, weighted by 2^8. With `b_i[7:0]` = 0, the product is exactly that value shifted left by 8.
- R5: `prod_o[7:0]` equals bits [7:0] of the low partition product, with no further addition.
- R6: `prod_o[23:8]` is the 16-bit sum of low partition bits [23:8] and high partition bits [15:0]. The carry-out of this sum goes to the upper section.
- R7: `prod_o[31:24]` equals high partition bits [23:16] plus one when the middle sum carries out, and equals those bits unchanged when it does not.
- R8: The +1 form is an excess-1 conversion. Bit 0 is inverted, and each higher bit is inverted when every lower bit is 1, so a run of trailing ones becomes zeros (for example 0x7F becomes 0x80).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 16 | Multiplicand, unsigned |
| b_i | input | 16 | Multiplier, unsigned; bits [7:0] feed the low partition, bits [15:8] feed the high partition |
| prod_o | output | 32 | Unsigned product |

## Verification
The hardest case to reach from the ports is a middle-band carry-out that meets a high-partition upper field ending in a run of ones. Only then does the excess-1 converter ripple past bit 0 before the select mux. The stimulus builds this case directly. It uses operands such as 0xFFFF times 0x80FF, where the high partition's upper byte is 0x7F and the middle band overflows, alongside all-ones operands. Single-byte multipliers isolate each partition, walking single bits probe every column, and a long run of random pairs covers both carry polarities in the select stage.

// File: rtl/dadda_split_mul_pkg.sv
`timescale 1ns/1ps
package dadda_split_mul_pkg;

  // Number of reduction stages needed to bring height h down to 2
  function automatic int dadda_stage_cnt(input int h);
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < h) begin
      n = n + 1;
      d = (d * 3) / 2;
    end
    return n;
  endfunction

  // k-th target height of the sequence 2,3,4,6,9,13,...
  function automatic int dadda_target(input int k);
    int d;
    d = 2;
    for (int i = 0; i < k; i++) d = (d * 3) / 2;
    return d;
  endfunction

  function automatic int min_int(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  function automatic int max_int(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/dadda_split_mul_tree.sv
`timescale 1ns/1ps
module dadda_split_mul_tree
  import dadda_split_mul_pkg::*;
#(
  parameter int W    = 16,
  parameter int ROWS = 8
) (
  input  logic [W-1:0]      pp_i [ROWS],
  output logic [W+ROWS-1:0] row0_o,
  output logic [W+ROWS-1:0] row1_o
);

  localparam int COLS = W + ROWS;
  localparam int HMIN = min_int(W, ROWS);
  localparam int CAP  = max_int(max_int(W, ROWS), 2);
  localparam int NSTG = dadda_stage_cnt(HMIN);

  logic [CAP-1:0] cur [COLS];
  logic [CAP-1:0] nxt [COLS];
  int             ht  [COLS];
  int             nh  [COLS];
  int             tgt, exc, nfa, nha, ptr;

  always_comb begin
    tgt = 2;
    exc = 0;
    nfa = 0;
    nha = 0;
    ptr = 0;
    for (int c = 0; c < COLS; c++) begin
      cur[c] = '0;
      nxt[c] = '0;
      ht[c]  = 0;
      nh[c]  = 0;
    end
    // load the shifted partial-product rows into columns
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < W; j++) begin
        cur[r+j][ht[r+j]] = pp_i[r][j];
        ht[r+j] = ht[r+j] + 1;
      end
    end
    for (int s = NSTG - 1; s >= 0; s--) begin
      tgt = dadda_target(s);
      for (int c = 0; c < COLS; c++) begin
        nxt[c] = '0;
        nh[c]  = 0;
      end
      for (int c = 0; c < COLS; c++) begin
        // excess over target, counting carries already landed here
        exc = ht[c] + nh[c] - tgt;
        nfa = (exc > 0) ? exc / 2 : 0;
        nha = (exc > 0) ? exc % 2 : 0;
        ptr = 0;
        for (int k = 0; k < CAP; k++) begin
          if (k < nfa) begin
            nxt[c][nh[c]] = cur[c][ptr] ^ cur[c][ptr+1] ^ cur[c][ptr+2];
            nh[c] = nh[c] + 1;
            if (c < COLS - 1) begin
              nxt[c+1][nh[c+1]] = (cur[c][ptr] & cur[c][ptr+1]) |
                                  (cur[c][ptr] & cur[c][ptr+2]) |
                                  (cur[c][ptr+1] & cur[c][ptr+2]);
              nh[c+1] = nh[c+1] + 1;
            end
            ptr = ptr + 3;
          end
        end
        if (nha == 1) begin
          nxt[c][nh[c]] = cur[c][ptr] ^ cur[c][ptr+1];
          nh[c] = nh[c] + 1;
          if (c < COLS - 1) begin
            nxt[c+1][nh[c+1]] = cur[c][ptr] & cur[c][ptr+1];
            nh[c+1] = nh[c+1] + 1;
          end
          ptr = ptr + 2;
        end
        for (int k = 0; k < CAP; k++) begin
          if (k >= ptr && k < ht[c]) begin
            nxt[c][nh[c]] = cur[c][k];
            nh[c] = nh[c] + 1;
          end
        end
      end
      for (int c = 0; c < COLS; c++) begin
        cur[c] = nxt[c];
        ht[c]  = nh[c];
      end
    end
    for (int c = 0; c < COLS; c++) begin
      row0_o[c] = cur[c][0];
      row1_o[c] = cur[c][1];
    end
  end

endmodule

// File: rtl/dadda_split_mul_part.sv
`timescale 1ns/1ps
module dadda_split_mul_part #(
  parameter int W    = 16,
  parameter int ROWS = 8
) (
  input  logic [W-1:0]      a_i,
  input  logic [ROWS-1:0]   b_i,
  output logic [W+ROWS-1:0] prod_o
);

  localparam int COLS = W + ROWS;

  logic [W-1:0]    pp [ROWS];
  logic [COLS-1:0] row0, row1;

  for (genvar r = 0; r < ROWS; r++) begin : g_pp
    assign pp[r] = a_i & {W{b_i[r]}};
  end

  dadda_split_mul_tree #(
    .W    (W),
    .ROWS (ROWS)
  ) tree_i (
    .pp_i   (pp),
    .row0_o (row0),
    .row1_o (row1)
  );

  // partition carry-propagate adder
  assign prod_o = row0 + row1;

endmodule

// File: rtl/dadda_split_mul_ripple.sv
`timescale 1ns/1ps
module dadda_split_mul_ripple #(
  parameter int N = 16
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  logic [N:0] cy;

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    assign cy[i+1]  = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
  end

  assign cout_o = cy[N];

endmodule

// File: rtl/dadda_split_mul_bec.sv
`timescale 1ns/1ps
module dadda_split_mul_bec #(
  parameter int N = 8
) (
  input  logic [N-1:0] val_i,
  output logic [N-1:0] inc_o
);

  logic [N-1:0] ones_below;

  assign ones_below[0] = 1'b1;

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign ones_below[i] = ones_below[i-1] & val_i[i-1];
  end

  assign inc_o = val_i ^ ones_below;

endmodule

// File: rtl/dadda_split_mul.sv
`timescale 1ns/1ps
module dadda_split_mul #(
  parameter int WIDTH   = 16,
  parameter int SPLIT   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] prod_o
);

  localparam int PW      = 2 * WIDTH;
  localparam int HI_ROWS = WIDTH - SPLIT;
  localparam int LO_W    = WIDTH + SPLIT;
  localparam int HI_W    = WIDTH + HI_ROWS;
  localparam int UP_W    = HI_ROWS;

  logic [LO_W-1:0]  lo_prod;
  logic [HI_W-1:0]  hi_prod;
  logic [WIDTH-1:0] mid_sum;
  logic             mid_cout;
  logic [UP_W-1:0]  up_raw, up_inc, up_sel;
  logic [PW-1:0]    prod_comb;

  dadda_split_mul_part #(
    .W    (WIDTH),
    .ROWS (SPLIT)
  ) lo_part_i (
    .a_i    (a_i),
    .b_i    (b_i[SPLIT-1:0]),
    .prod_o (lo_prod)
  );

  dadda_split_mul_part #(
    .W    (WIDTH),
    .ROWS (HI_ROWS)
  ) hi_part_i (
    .a_i    (a_i),
    .b_i    (b_i[WIDTH-1:SPLIT]),
    .prod_o (hi_prod)
  );

  // overlap band
  dadda_split_mul_ripple #(
    .N (WIDTH)
  ) mid_add_i (
    .x_i    (lo_prod[LO_W-1:SPLIT]),
    .y_i    (hi_prod[WIDTH-1:0]),
    .sum_o  (mid_sum),
    .cout_o (mid_cout)
  );

  // carry-select upper section
  assign up_raw = hi_prod[HI_W-1:WIDTH];

  dadda_split_mul_bec #(
    .N (UP_W)
  ) up_bec_i (
    .val_i (up_raw),
    .inc_o (up_inc)
  );

  assign up_sel    = mid_cout ? up_inc : up_raw;
  assign prod_comb = {up_sel, mid_sum, lo_prod[SPLIT-1:0]};

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_o <= '0;
      else         prod_o <= prod_comb;
    end

    // R2
    prod_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> prod_o == $past(PW'(a_i) * PW'(b_i)));
  end else begin : g_comb
    assign prod_o = prod_comb;
  end

  // R1
  prod_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_comb == PW'(a_i) * PW'(b_i));

  // R3
  lo_part_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_prod == LO_W'(a_i) * LO_W'(b_i[SPLIT-1:0]));

  // R4
  hi_part_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_prod == HI_W'(a_i) * HI_W'(b_i[WIDTH-1:SPLIT]));

  // R6
  mid_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {mid_cout, mid_sum} == (WIDTH+1)'(lo_prod[LO_W-1:SPLIT]) + (WIDTH+1)'(hi_prod[WIDTH-1:0]));

  // R7
  up_sel_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_cout |-> up_sel == up_raw + UP_W'(1));

  // R7
  up_sel_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mid_cout |-> up_sel == up_raw);

  // R8
  bec_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_inc == up_raw + UP_W'(1));

endmodule

// File: tb/dadda_split_mul_tb_top.sv
`timescale 1ns/1ps
module dadda_split_mul_tb_top;

  localparam int HALF_NS  = 4;
  localparam int MAX_CYC  = 200000;

  typedef struct {
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [31:0] prod_o;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  dadda_split_mul dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o)
  );

  always #HALF_NS clk_i = ~clk_i;

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input string tag);
    item_t it;
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    it.a   = a;
    it.b   = b;
    it.exp = {16'h0, a} * {16'h0, b};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: sample 2 ns after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_vec++;
        if (prod_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s a=%h b=%h actual=%h expected=%h", it.tag, it.a, it.b, prod_o, it.exp);
        end
      end
    end
  end

  initial begin
    #(2 * HALF_NS * MAX_CYC);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    a_i = 16'hFFFF;
    b_i = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (prod_o !== 32'h0) begin
      n_bad++;
      $display("FAIL R2 reset actual=%h expected=%h", prod_o, 32'h0);
    end
    rst_ni = 1'b1;

    // R1: corner operands
    drive(16'h0000, 16'h0000, "R1 zeros");
    drive(16'hFFFF, 16'h0000, "R1 zero mult");
    drive(16'h0000, 16'hFFFF, "R1 zero mcand");
    drive(16'hFFFF, 16'hFFFF, "R1 ones");
    drive(16'h0001, 16'h0001, "R1 unit");
    // R2: back-to-back operand changes each cycle
    drive(16'h1234, 16'h5678, "R2 seq0");
    drive(16'hABCD, 16'h0003, "R2 seq1");
    // R3: high multiplier byte zero
    drive(16'hFFFF, 16'h00FF, "R3 lo only");
    drive(16'hA5A5, 16'h005A, "R3 lo pattern");
    // R4: low multiplier byte zero
    drive(16'hFFFF, 16'hFF00, "R4 hi only");
    drive(16'h5A5A, 16'hA500, "R4 hi pattern");
    // R5: low byte pass-through with walking multiplicand bit
    for (int i = 0; i < 16; i++) drive(16'(1 << i), 16'h00B7, "R5 walk");
    // R6: walking single bits across both operands
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) drive(16'(1 << i), 16'(1 << j), "R6 single");
    // R7: carry and no-carry into upper section
    drive(16'hFFFF, 16'hFFFF, "R7 carry");
    drive(16'h0100, 16'h0100, "R7 no carry");
    drive(16'hFFFF, 16'hFF01, "R7 mixed");
    // R8: increment ripples through a run of ones
    drive(16'hFFFF, 16'h80FF, "R8 run7");
    drive(16'hFFFF, 16'hC0FF, "R8 run6");
    drive(16'hFFFF, 16'h01FF, "R8 low");
    // R1: random pairs
    for (int i = 0; i < 600; i++) drive(16'($urandom), 16'($urandom), "R1 random");

    @(negedge clk_i);
    a_i = '0;
    b_i = '0;
    while (q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule